// File: doc/BRIEF.md
# Serial Port Register File with Baud Divider

This block is the register front end of a classic byte-wide serial port. A host reaches eight byte registers through a 3-bit offset, with separate read and write strobes. The offset alone does not pick the register. Offset 2 reads the interrupt identification value and writes the FIFO control value. Offsets 0 and 1 switch to the two bytes of a 16-bit divisor while the divisor-access bit (line control bit 7) is set.

The block keeps these registers locally:
- line control
- interrupt enable
- modem control
- scratch
- the divisor

It decodes line control into word-length, stop-bit and parity fields for the shift logic. It also produces a clock-enable pulse at sixteen times the bit rate. The bit rate is the clock divided by sixteen times the divisor: a 1.8432 MHz clock with divisor 12 gives 9600 baud, and divisor 1 gives 115200.

Shift registers, FIFOs and interrupt priority are outside the block. They connect through ports:
- received byte and status values come in;
- transmit, receive-pop and FIFO-control strobes go out.

On line status, bit 5 flags an empty transmit holding register and bit 6 flags that both the holding and shift registers are empty. Those bits come from the transmitter and are passed through unchanged.

Top module: `uart_regfile`

## Requirements
- R1: After a synchronous reset, line control, interrupt enable, modem control, scratch and divisor are all zero. `rdata` is zero, every strobe is low and `baud_tick` stays low.
- R2: While line control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes. While that bit is 0, a read of offset 0 returns `rx_data` and offset 1 is the interrupt enable register.
- R3: A write to offset 0 with line control bit 7 clear raises `tx_push` for exactly the next cycle, with `wr_byte` holding the written byte. With that bit set, no push occurs.
- R4: A read of offset 0 raises `rx_pop` for one cycle only when line control bit 7 is 0.
- R5: A read of offset 2 returns `int_id`. A write to offset 2 raises `fcr_push` for one cycle with the byte on `wr_byte`.
- R6: Offsets 1 (with bit 7 clear), 3, 4 and 7 read back the last byte written there.
- R7: Reads of offsets 5 and 6 return `line_stat` and `modem_stat`. Writes there change no register and raise no strobe.
- R8: `data_bits` equals line control bits 1:0 plus five (5 to 8). `two_stop` equals line control bit 2.
- R9: `par_en` equals line control bit 3. `par_sel` equals line control bits 5:4, with 0 for odd, 1 for even, 2 for mark and 3 for space.
- R10: With a divisor N ≥ 1, `baud_tick` is a one-cycle pulse every N clock cycles. With N = 1 it is high every cycle.
- R11: A divisor of 0 holds `baud_tick` low.
- R12: Writing either divisor byte restarts the divider. The first tick appears exactly N cycles after the write edge.
- R13: `rdata` updates one cycle after a read strobe and holds its value when no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rx_data | input | 8 | Received byte from the receive path |
| int_id | input | 8 | Interrupt identification value |
| line_stat | input | 8 | Line status value |
| modem_stat | input | 8 | Modem status value |
| rdata | output | 8 | Registered read data |
| tx_push | output | 1 | One-cycle transmit byte strobe |
| fcr_push | output | 1 | One-cycle FIFO control strobe |
| wr_byte | output | 8 | Byte accompanying tx_push or fcr_push |
| rx_pop | output | 1 | One-cycle receive pop strobe |
| ier | output | 8 | Interrupt enable register |
| mcr | output | 8 | Modem control register |
| data_bits | output | 4 | Word length, 5 to 8 |
| two_stop | output | 1 | Two stop bits selected |
| par_en | output | 1 | Parity enabled |
| par_sel | output | 2 | Parity kind: 0 odd, 1 even, 2 mark, 3 space |
| divisor | output | 16 | Programmed divisor |
| baud_tick | output | 1 | 16x bit-rate clock enable |

## Verification
The bench checks offsets 0 and 1 on both sides of the bank bit. A decoder that ignored the bank bit would return `rx_data` instead of the divisor, or would push a divisor write into the transmitter.

It writes the read-only offsets and then reads every stored register back. This catches a decoder that lets offset 5 or 6 land in another register.

The divider is timed from the write edge for divisors 1, 4, 6 and 0, including a rewrite in the middle of a count. An off-by-one counter, a missing restart or a free-running zero divisor each show up as a wrong first-tick cycle or a wrong tick count.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LINE  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } ofs_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } par_e;
endpackage

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
  import uart_regs_pkg::*;
#(
  parameter int DW = 8,
  localparam int DIVW = 2 * DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [OFS_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   lcr_q,
  output logic [DW-1:0]   ier_q,
  output logic [DW-1:0]   mcr_q,
  output logic [DW-1:0]   scr_q,
  output logic [DIVW-1:0] div_q,
  output logic            div_load,
  output logic            tx_push,
  output logic            fcr_push,
  output logic [DW-1:0]   wr_byte
);
  ofs_e ofs;
  logic bank;
  logic wr_tx, wr_fcr;

  assign ofs  = ofs_e'(addr);
  assign bank = lcr_q[DW-1];

  always_comb begin
    wr_tx    = wr_en && (ofs == OFS_DATA) && !bank;
    wr_fcr   = wr_en && (ofs == OFS_IID);
    div_load = wr_en && bank && ((ofs == OFS_DATA) || (ofs == OFS_IEN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q    <= '0;
      ier_q    <= '0;
      mcr_q    <= '0;
      scr_q    <= '0;
      div_q    <= '0;
      tx_push  <= 1'b0;
      fcr_push <= 1'b0;
      wr_byte  <= '0;
    end else begin
      tx_push  <= wr_tx;
      fcr_push <= wr_fcr;
      if (wr_tx || wr_fcr) wr_byte <= wdata;
      if (wr_en) begin
        case (ofs)
          OFS_DATA: if (bank) div_q[DW-1:0] <= wdata;
          OFS_IEN:  if (bank) div_q[DIVW-1:DW] <= wdata;
                    else      ier_q <= wdata;
          OFS_LINE: lcr_q <= wdata;
          OFS_MCTL: mcr_q <= wdata;
          OFS_SCR:  scr_q <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
  import uart_regs_pkg::*;
#(
  parameter int DW = 8,
  localparam int DIVW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] addr,
  input  logic             bank,
  input  logic [DW-1:0]    rx_data,
  input  logic [DW-1:0]    int_id,
  input  logic [DW-1:0]    line_stat,
  input  logic [DW-1:0]    modem_stat,
  input  logic [DW-1:0]    lcr_q,
  input  logic [DW-1:0]    ier_q,
  input  logic [DW-1:0]    mcr_q,
  input  logic [DW-1:0]    scr_q,
  input  logic [DIVW-1:0]  div_q,
  output logic [DW-1:0]    rdata,
  output logic             rx_pop
);
  ofs_e ofs;
  logic [DW-1:0] sel;

  assign ofs = ofs_e'(addr);

  always_comb begin
    case (ofs)
      OFS_DATA:  sel = bank ? div_q[DW-1:0] : rx_data;
      OFS_IEN:   sel = bank ? div_q[DIVW-1:DW] : ier_q;
      OFS_IID:   sel = int_id;
      OFS_LINE:  sel = lcr_q;
      OFS_MCTL:  sel = mcr_q;
      OFS_LSTAT: sel = line_stat;
      OFS_MSTAT: sel = modem_stat;
      default:   sel = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rx_pop <= 1'b0;
    end else begin
      rx_pop <= rd_en && (ofs == OFS_DATA) && !bank;
      if (rd_en) rdata <= sel;
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] divisor,
  output logic          tick
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == divisor - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || load || (divisor == '0)) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (at_end) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] int_id,
  input  logic [DATA_W-1:0] line_stat,
  input  logic [DATA_W-1:0] modem_stat,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_push,
  output logic              fcr_push,
  output logic [DATA_W-1:0] wr_byte,
  output logic              rx_pop,
  output logic [DATA_W-1:0] ier,
  output logic [DATA_W-1:0] mcr,
  output logic [3:0]        data_bits,
  output logic              two_stop,
  output logic              par_en,
  output logic [1:0]        par_sel,
  output logic [DIV_W-1:0]  divisor,
  output logic              baud_tick
);
  logic [DATA_W-1:0] lcr_q, ier_q, mcr_q, scr_q;
  logic [DIV_W-1:0]  div_q;
  logic              div_load;

  uart_reg_bank #(.DW(DATA_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .lcr_q    (lcr_q),
    .ier_q    (ier_q),
    .mcr_q    (mcr_q),
    .scr_q    (scr_q),
    .div_q    (div_q),
    .div_load (div_load),
    .tx_push  (tx_push),
    .fcr_push (fcr_push),
    .wr_byte  (wr_byte)
  );

  uart_read_mux #(.DW(DATA_W)) u_rmux (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .addr       (addr),
    .bank       (lcr_q[DATA_W-1]),
    .rx_data    (rx_data),
    .int_id     (int_id),
    .line_stat  (line_stat),
    .modem_stat (modem_stat),
    .lcr_q      (lcr_q),
    .ier_q      (ier_q),
    .mcr_q      (mcr_q),
    .scr_q      (scr_q),
    .div_q      (div_q),
    .rdata      (rdata),
    .rx_pop     (rx_pop)
  );

  uart_baud_gen #(.CW(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .load    (div_load),
    .divisor (div_q),
    .tick    (baud_tick)
  );

  // Line format decode for the shift logic
  assign data_bits = 4'd5 + {2'b00, lcr_q[1:0]};
  assign two_stop  = lcr_q[2];
  assign par_en    = lcr_q[3];
  assign par_sel   = lcr_q[5:4];
  assign ier       = ier_q;
  assign mcr       = mcr_q;
  assign divisor   = div_q;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int DATA_W = 8,
  localparam int DIV_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rdata,
  input logic              tx_push,
  input logic              fcr_push,
  input logic              rx_pop,
  input logic              baud_tick,
  input logic [DIV_W-1:0]  divisor,
  input logic              div_load,
  input logic [DATA_W-1:0] lcr_q,
  input logic [DATA_W-1:0] ier_q,
  input logic [DATA_W-1:0] mcr_q,
  input logic [DATA_W-1:0] scr_q
);
  assert_tx_push_cause_R3: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(wr_en && addr == 3'd0 && !lcr_q[DATA_W-1]));

  assert_rx_pop_cause_R4: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(rd_en && addr == 3'd0 && !lcr_q[DATA_W-1]));

  assert_ro_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == 3'd5 || addr == 3'd6)) |=>
      ($stable(lcr_q) && $stable(ier_q) && $stable(mcr_q) && $stable(scr_q)
       && $stable(divisor) && !tx_push && !fcr_push));

  assert_tick_single_R10: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && divisor > DIV_W'(1) && !div_load) |=> !baud_tick);

  assert_tick_stopped_R11: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0) |=> !baud_tick);

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .rdata     (rdata),
  .tx_push   (tx_push),
  .fcr_push  (fcr_push),
  .rx_pop    (rx_pop),
  .baud_tick (baud_tick),
  .divisor   (divisor),
  .div_load  (div_load),
  .lcr_q     (lcr_q),
  .ier_q     (ier_q),
  .mcr_q     (mcr_q),
  .scr_q     (scr_q)
);

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rx_data = 8'hA5, int_id = 8'hC1, line_stat = 8'h60, modem_stat = 8'hB0;
  logic [7:0] rdata, wr_byte, ier, mcr;
  logic       tx_push, fcr_push, rx_pop, two_stop, par_en, baud_tick;
  logic [3:0] data_bits;
  logic [1:0] par_sel;
  logic [15:0] divisor;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rx_data(rx_data), .int_id(int_id),
    .line_stat(line_stat), .modem_stat(modem_stat), .rdata(rdata),
    .tx_push(tx_push), .fcr_push(fcr_push), .wr_byte(wr_byte),
    .rx_pop(rx_pop), .ier(ier), .mcr(mcr), .data_bits(data_bits),
    .two_stop(two_stop), .par_en(par_en), .par_sel(par_sel),
    .divisor(divisor), .baud_tick(baud_tick)
  );

  // {is_read, offset, write data, expected read data}
  localparam int NVEC = 20;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 3'd3, 8'h83, 8'h00},
    {1'b0, 3'd0, 8'h0C, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'h0C},
    {1'b1, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd3, 8'h00, 8'h83},
    {1'b0, 3'd3, 8'h03, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'hA5},
    {1'b0, 3'd1, 8'h0F, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h0F},
    {1'b0, 3'd7, 8'h5A, 8'h00},
    {1'b1, 3'd7, 8'h00, 8'h5A},
    {1'b0, 3'd4, 8'h13, 8'h00},
    {1'b1, 3'd4, 8'h00, 8'h13},
    {1'b1, 3'd2, 8'h00, 8'hC1},
    {1'b0, 3'd5, 8'hFF, 8'h00},
    {1'b1, 3'd5, 8'h00, 8'h60},
    {1'b0, 3'd6, 8'h00, 8'h00},
    {1'b1, 3'd6, 8'h00, 8'hB0},
    {1'b1, 3'd3, 8'h00, 8'h03}
  };

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R5";
      3'd5, 3'd6: return "R7";
      default:    return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives at a falling edge, returns at the falling edge after the capturing rising edge
  task automatic access(input bit rd, input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; rd_en = rd; wr_en = !rd;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic first_tick(input int limit, output int k_out);
    k_out = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (baud_tick && k_out < 0) begin
        k_out = k;
        break;
      end
    end
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (baud_tick) c++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ft, nt;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", 32'(rdata), 32'h0);
    chk("R1 divisor", 32'(divisor), 32'h0);
    chk("R1 strobes", {29'h0, tx_push, fcr_push, rx_pop}, 32'h0);
    chk("R1 ier/mcr", {16'h0, ier, mcr}, 32'h0);
    chk("R1 data_bits", 32'(data_bits), 32'd5);
    count_ticks(30, nt);
    chk("R1 no tick", 32'(nt), 32'd0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      if (VEC[i][19]) chk(tag_of(VEC[i][18:16]), 32'(rdata), 32'(VEC[i][7:0]));
    end

    // R13 rdata holds without read
    repeat (5) @(negedge clk);
    chk("R13 hold", 32'(rdata), 32'h03);

    // R3 transmit strobe, bank clear
    access(1'b0, 3'd0, 8'h41);
    chk("R3 push", {23'h0, tx_push, wr_byte}, {23'h0, 1'b1, 8'h41});
    @(negedge clk);
    chk("R3 one cycle", 32'(tx_push), 32'h0);
    // R4 pop with bank clear
    access(1'b1, 3'd0, 8'h00);
    chk("R4 pop", 32'(rx_pop), 32'h1);
    @(negedge clk);
    chk("R4 one cycle", 32'(rx_pop), 32'h0);
    // R5 fifo control write
    access(1'b0, 3'd2, 8'h07);
    chk("R5 fcr push", {23'h0, fcr_push, wr_byte}, {23'h0, 1'b1, 8'h07});
    // R7 writes to read-only offsets: no strobes, registers unchanged
    access(1'b0, 3'd5, 8'hEE);
    chk("R7 no strobe", {30'h0, tx_push, fcr_push}, 32'h0);
    access(1'b0, 3'd6, 8'hDD);
    access(1'b1, 3'd7, 8'h00);
    chk("R7 scratch kept", 32'(rdata), 32'h5A);
    access(1'b1, 3'd4, 8'h00);
    chk("R7 mcr kept", 32'(rdata), 32'h13);
    access(1'b1, 3'd1, 8'h00);
    chk("R7 ier kept", 32'(rdata), 32'h0F);

    // R8 / R9 format decode
    access(1'b0, 3'd3, 8'h3F);
    chk("R8 8 bits 2 stop", {27'h0, data_bits, two_stop}, {27'h0, 4'd8, 1'b1});
    chk("R9 space", {29'h0, par_en, par_sel}, {29'h0, 1'b1, 2'd3});
    access(1'b0, 3'd3, 8'h08);
    chk("R8 5 bits 1 stop", {27'h0, data_bits, two_stop}, {27'h0, 4'd5, 1'b0});
    chk("R9 odd", {29'h0, par_en, par_sel}, {29'h0, 1'b1, 2'd0});
    access(1'b0, 3'd3, 8'h1A);
    chk("R8 7 bits", 32'(data_bits), 32'd7);
    chk("R9 even", {29'h0, par_en, par_sel}, {29'h0, 1'b1, 2'd1});
    access(1'b0, 3'd3, 8'h29);
    chk("R9 mark", {29'h0, par_en, par_sel}, {29'h0, 1'b1, 2'd2});
    access(1'b0, 3'd3, 8'h30);
    chk("R9 none", 32'(par_en), 32'h0);

    // R3 bank set: divisor write must not push
    access(1'b0, 3'd3, 8'h80);
    access(1'b0, 3'd0, 8'h04);
    chk("R3 no push in bank", 32'(tx_push), 32'h0);
    access(1'b0, 3'd1, 8'h00);
    chk("R2 divisor", 32'(divisor), 32'd4);
    // R4 no pop in bank
    access(1'b1, 3'd0, 8'h00);
    chk("R4 no pop in bank", 32'(rx_pop), 32'h0);
    chk("R2 div low read", 32'(rdata), 32'h04);

    // R10 / R12 divisor 4
    access(1'b0, 3'd0, 8'h04);
    first_tick(20, ft);
    chk("R12 first tick div4", 32'(ft), 32'd4);
    count_ticks(16, nt);
    chk("R10 period div4", 32'(nt), 32'd4);

    // R12 restart mid-count, divisor 6
    access(1'b0, 3'd0, 8'h06);
    repeat (3) @(negedge clk);
    access(1'b0, 3'd1, 8'h00);
    first_tick(20, ft);
    chk("R12 restart div6", 32'(ft), 32'd6);
    count_ticks(24, nt);
    chk("R10 period div6", 32'(nt), 32'd4);

    // R10 divisor 1: every cycle
    access(1'b0, 3'd0, 8'h01);
    first_tick(5, ft);
    chk("R10 first div1", 32'(ft), 32'd1);
    count_ticks(8, nt);
    chk("R10 every cycle", 32'(nt), 32'd8);

    // R11 divisor 0
    access(1'b0, 3'd0, 8'h00);
    count_ticks(40, nt);
    chk("R11 stopped", 32'(nt), 32'd0);

    // R2 high byte read in bank
    access(1'b0, 3'd1, 8'h09);
    access(1'b1, 3'd1, 8'h00);
    chk("R2 div high read", 32'(rdata), 32'h09);
    chk("R2 divisor value", 32'(divisor), 32'h0900);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule